// File: doc/BRIEF.md
# Framed Four-Bit Pattern Detector

The detector takes one serial bit per accepted clock edge and splits the accepted stream into fixed, non-overlapping frames of four bits. While the fourth bit of a frame is on its input, the single output goes high if the whole frame equals one of two fixed codes. After the fourth accepted bit the detector returns to its start state, whatever the frame held. A sliding search would reuse bits across frames; this block never does.

The two codes end in the same two bits. After the third bit, one shared tail state waits for the closing `1`. As soon as a prefix can no longer become either code, the detector moves to a dead state. It leaves that state only at the frame boundary. A bit is accepted only when `din_vld` is high. A synchronous reset puts the frame boundary back in place, so the next accepted bit becomes bit one of a frame.

Top module: `quad_frame_matcher`

## Requirements
- R1: After a synchronous reset, `hit` is 0 and the next accepted bit is bit one of a new frame. A reset in the middle of a frame drops the partial frame.
- R2: `hit` is 1 during the fourth accepted bit of a frame whose bits, in arrival order, are 0,1,0,1.
- R3: `hit` is 1 during the fourth accepted bit of a frame whose bits, in arrival order, are 1,0,0,1.
- R4: For each of the other fourteen four-bit frames, `hit` stays 0 on every bit. This includes frames that start 00 or 11, which enter the dead state after two bits.
- R5: `hit` is 0 while the first, second or third accepted bit of any frame is applied.
- R6: Frames are disjoint. The accepted bit after a fourth bit always starts a new frame, so a match is never formed from bits of two frames.
- R7: When `din_vld` is 0, `hit` is 0, the bit on `din` is ignored, and the frame position and the match progress are unchanged.
- R8: `hit` is combinational. It is valid in the same cycle as the fourth accepted bit, with no register delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data bit |
| din_vld | input | 1 | Accept strobe for `din` |
| hit | output | 1 | High while the fourth bit of a matching frame is applied |

## Verification
`hit` is combinational, so its result is due in the same cycle as the fourth accepted bit. The bench drives each bit at the falling edge and samples `hit` one nanosecond later, before the rising edge that consumes the bit. The frame position and match progress move only at that rising edge. The bench updates its own arithmetic model of frame position and bit history after the same edge, so every expectation applies to the bit currently on the inputs. The sweep covers all sixteen frames with no gaps, with idle cycles between bits, across a mid-frame reset, and in a stream where a sliding search would report a hit that the framed detector must not report.

// File: rtl/qfm_pkg.sv
package qfm_pkg;
   localparam int FRAME_LEN = 4;
   localparam int POS_W     = $clog2(FRAME_LEN);
   localparam logic [FRAME_LEN-1:0] CODE_A = 4'b0101;
   localparam logic [FRAME_LEN-1:0] CODE_B = 4'b1001;

   // progress states; ST_TAIL is shared by both codes after bit three
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_Z    = 3'd1,
      ST_O    = 3'd2,
      ST_ZO   = 3'd3,
      ST_OZ   = 3'd4,
      ST_TAIL = 3'd5,
      ST_DEAD = 3'd6
   } qfm_state_e;

   localparam int N_ST = 7;
endpackage

// File: rtl/qfm_frame_ctr.sv
module qfm_frame_ctr #(
   parameter int FRAME_LEN = 4,
   localparam int POS_W    = $clog2(FRAME_LEN)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   output logic [POS_W-1:0] pos,
   output logic             last
);
   generate
      if (FRAME_LEN < 2) begin : g_bad_len
         $error("qfm_frame_ctr: FRAME_LEN must be at least 2");
      end
   endgenerate

   localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

   logic [POS_W-1:0] pos_q;

   assign last = (pos_q == LAST_POS);
   assign pos  = pos_q;

   always_ff @(posedge clk) begin
      if (rst)
         pos_q <= '0;
      else if (adv)
         pos_q <= last ? '0 : pos_q + POS_W'(1);
   end
endmodule

// File: rtl/qfm_track_fsm.sv
module qfm_track_fsm
   import qfm_pkg::*;
#(
   parameter int STATE_STYLE = 0   // 0: binary register, 1: one-hot register
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       adv,
   input  logic       bit_in,
   input  logic       last,
   output qfm_state_e state
);
   generate
      if (STATE_STYLE != 0 && STATE_STYLE != 1) begin : g_bad_style
         $error("qfm_track_fsm: STATE_STYLE must be 0 or 1");
      end
   endgenerate

   qfm_state_e cur;
   qfm_state_e nxt;

   always_comb begin
      nxt = cur;
      if (adv) begin
         if (last) begin
            nxt = ST_IDLE;
         end else begin
            unique case (cur)
               ST_IDLE: nxt = bit_in ? ST_O    : ST_Z;
               ST_Z:    nxt = bit_in ? ST_ZO   : ST_DEAD;
               ST_O:    nxt = bit_in ? ST_DEAD : ST_OZ;
               ST_ZO:   nxt = bit_in ? ST_DEAD : ST_TAIL;
               ST_OZ:   nxt = bit_in ? ST_DEAD : ST_TAIL;
               default: nxt = ST_DEAD;
            endcase
         end
      end
   end

   generate
      if (STATE_STYLE == 1) begin : g_onehot
         logic [N_ST-1:0] oh_q;
         always_ff @(posedge clk) begin
            if (rst)
               oh_q <= N_ST'(1);
            else
               oh_q <= N_ST'(1) << nxt;
         end
         always_comb begin
            cur = ST_IDLE;
            for (int i = 0; i < N_ST; i++)
               if (oh_q[i]) cur = qfm_state_e'(3'(i));
         end
      end else begin : g_binary
         qfm_state_e st_q;
         always_ff @(posedge clk) begin
            if (rst)
               st_q <= ST_IDLE;
            else
               st_q <= nxt;
         end
         assign cur = st_q;
      end
   endgenerate

   assign state = cur;
endmodule

// File: rtl/qfm_hit_dec.sv
module qfm_hit_dec
   import qfm_pkg::*;
(
   input  qfm_state_e state,
   input  logic       adv,
   input  logic       bit_in,
   input  logic       last,
   output logic       hit
);
   // only the shared tail state can close a match, and only with a one
   always_comb begin
      hit = 1'b0;
      if (adv && last && state == ST_TAIL)
         hit = bit_in;
   end
endmodule

// File: rtl/quad_frame_matcher.sv
module quad_frame_matcher
   import qfm_pkg::*;
#(
   parameter int STATE_STYLE = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   input  logic din_vld,
   output logic hit
);
   logic [POS_W-1:0] pos_q;
   logic             at_last;
   qfm_state_e       trk_state;

   qfm_frame_ctr #(.FRAME_LEN(FRAME_LEN)) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .adv  (din_vld),
      .pos  (pos_q),
      .last (at_last)
   );

   qfm_track_fsm #(.STATE_STYLE(STATE_STYLE)) u_fsm (
      .clk    (clk),
      .rst    (rst),
      .adv    (din_vld),
      .bit_in (din),
      .last   (at_last),
      .state  (trk_state)
   );

   qfm_hit_dec u_dec (
      .state  (trk_state),
      .adv    (din_vld),
      .bit_in (din),
      .last   (at_last),
      .hit    (hit)
   );
endmodule

// File: rtl/quad_frame_matcher_chk.sv
module quad_frame_matcher_chk
   import qfm_pkg::*;
(
   input logic             clk,
   input logic             rst,
   input logic             din,
   input logic             din_vld,
   input logic             hit,
   input logic [POS_W-1:0] pos,
   input qfm_state_e       state
);
   localparam logic [POS_W-1:0] LASTP = POS_W'(FRAME_LEN - 1);

   logic [FRAME_LEN-2:0] hist;
   logic                 rst_q;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst)
         hist <= '0;
      else if (din_vld)
         hist <= {hist[FRAME_LEN-3:0], din};
      if (rst_q && !rst)
         a_r1_reset_align: assert (pos == '0 && state == ST_IDLE);
   end

   a_r2_r3_frame_match: assert property (@(posedge clk) disable iff (rst)
      (din_vld && pos == LASTP) |->
         (hit == ({hist, din} == CODE_A || {hist, din} == CODE_B)));

   a_r5_early_bits_low: assert property (@(posedge clk) disable iff (rst)
      (pos != LASTP) |-> !hit);

   a_r6_frame_restart: assert property (@(posedge clk) disable iff (rst)
      (din_vld && pos == LASTP) |=> (pos == '0 && state == ST_IDLE));

   a_r4_dead_holds: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DEAD && din_vld && pos != LASTP) |=> state == ST_DEAD);

   a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !din_vld |-> !hit);

   a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !din_vld |=> ($stable(pos) && $stable(state)));
endmodule

bind quad_frame_matcher quad_frame_matcher_chk u_chk (
   .clk     (clk),
   .rst     (rst),
   .din     (din),
   .din_vld (din_vld),
   .hit     (hit),
   .pos     (pos_q),
   .state   (trk_state)
);

// File: tb/quad_frame_matcher_bench.sv
`timescale 1ns/1ps
module quad_frame_matcher_bench;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic din = 1'b0;
   logic din_vld = 1'b0;
   logic hit;

   int n_vec = 0;
   int n_bad = 0;
   int m_pos = 0;        // bench model: frame position
   logic [2:0] m_sh = '0; // bench model: earlier bits of the frame
   bit done = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   quad_frame_matcher u_quad_frame_matcher (
      .clk(clk), .rst(rst), .din(din), .din_vld(din_vld), .hit(hit)
   );

   task automatic check(input logic exp, input string tag);
      n_vec++;
      if (hit !== exp) begin
         n_bad++;
         $display("FAIL %s: hit=%b expected=%b (pos %0d)", tag, hit, exp, m_pos);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; din_vld = 1'b0; din = 1'b1;
      @(posedge clk); @(posedge clk);
      #1 check(1'b0, "R1 reset");
      @(negedge clk);
      rst = 1'b0;
      m_pos = 0; m_sh = '0;
   endtask

   // apply one bit, check hit in the same cycle, then update the model
   task automatic apply(input logic b, input logic v, input string force_tag);
      logic exp;
      string tag;
      logic [3:0] fr;
      @(negedge clk);
      din = b; din_vld = v;
      fr = {m_sh, b};
      if (!v) begin
         exp = 1'b0; tag = "R7 idle";
      end else if (m_pos != 3) begin
         exp = 1'b0; tag = "R5 early bit";
      end else if (fr == 4'b0101) begin
         exp = 1'b1; tag = "R2 code 0101 (R8 same cycle)";
      end else if (fr == 4'b1001) begin
         exp = 1'b1; tag = "R3 code 1001 (R8 same cycle)";
      end else begin
         exp = 1'b0; tag = "R4 other frame";
      end
      if (force_tag != "") tag = force_tag;
      #1 check(exp, tag);
      @(posedge clk);
      if (v) begin
         m_sh = {m_sh[1:0], b};
         m_pos = (m_pos + 1) % 4;
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 8);
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      report();
   end

   initial begin
      do_reset();
      // R1: first accepted bit after reset is bit one
      apply(1'b1, 1'b1, "");
      apply(1'b0, 1'b1, "");
      apply(1'b0, 1'b1, "");
      apply(1'b1, 1'b1, "R1 first frame after reset");

      // back-to-back sweep of all sixteen frames, twice
      for (int p = 0; p < 2; p++)
         for (int f = 0; f < 16; f++)
            for (int k = 3; k >= 0; k--)
               apply(f[k], 1'b1, "");

      // sweep with idle cycles between bits; the idle bit is the inverse
      for (int f = 0; f < 16; f++)
         for (int k = 3; k >= 0; k--) begin
            apply(~f[k], 1'b0, "");
            apply(f[k], 1'b1, "");
            if (k == 1) apply(1'b1, 1'b0, "R7 idle before last bit");
         end

      // R6: sliding search would match at bits 3..6; framed must not
      apply(1'b1, 1'b1, "");
      apply(1'b1, 1'b1, "");
      apply(1'b0, 1'b1, "");
      apply(1'b1, 1'b1, "R6 frame one");
      apply(1'b0, 1'b1, "R6 no overlap");
      apply(1'b1, 1'b1, "R6 no overlap");
      apply(1'b1, 1'b1, "R6 no overlap");
      apply(1'b1, 1'b1, "R6 no overlap");

      // R1: reset mid-frame drops the partial frame
      apply(1'b0, 1'b1, "");
      apply(1'b1, 1'b1, "");
      do_reset();
      for (int k = 3; k >= 0; k--)
         apply(logic'((4'b1001 >> k) & 4'd1), 1'b1, k == 0 ? "R1 realigned match" : "");
      apply(1'b0, 1'b1, "");
      apply(1'b1, 1'b1, "");
      apply(1'b0, 1'b1, "");
      do_reset();
      apply(1'b1, 1'b1, "R1 partial 010 discarded");
      for (int k = 2; k >= 0; k--)
         apply(logic'((4'b0101 >> k) & 4'd1), 1'b1, "");

      report();
   end
endmodule